// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one pulse-width modulation channel built around an 8-bit counter that advances on a clock-enable tick from an external prescaler. A period value sets how long one output cycle lasts and a duty value sets how long the output stays high within it. Two counting styles are offered: edge-aligned, where the counter climbs and wraps, and centred, where it climbs to the period value and then falls back, so the high pulse sits symmetrically around the turning point.

Period and duty each sit behind two storage stages: a software-visible holding stage and a live stage that drives the comparison. While the channel runs, new values land only in the holding stage and move into the live stage at a safe point, so every output cycle is entirely the old shape or entirely the new one. A write of any value to the counter clears it, which also counts as a safe point. Software reaches period, duty and counter through a simple register write and read port.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: After reset the counter, both holding stages and both live stages are zero, and `pwm_out` is low.
- R2: While `chan_en` is low the counter stays at zero, ticks have no effect on it and `pwm_out` is low.
- R3: While enabled, the counter changes only on cycles where `tick` is high (or on a counter write).
- R4: With `center_mode` low, each tick moves the counter from 0 up to P-1 and then back to 0, where P is the live period, so one output cycle lasts P ticks; a live period of 0 or 1 keeps the counter at 0 and closes a cycle on every tick.
- R5: With `center_mode` high, the counter climbs by one per tick up to P, then falls by one per tick to 0, so one output cycle lasts 2*P ticks; a live period of 0 keeps the counter at 0 and closes a cycle on every tick.
- R6: While enabled, `pwm_out` is high exactly when the counter value is below the live duty value.
- R7: While enabled, a write to period or duty changes only its holding stage; the live stage takes the holding value only when an output cycle closes (edge-aligned wrap to 0, or centred return to 0) or on a counter write. A write in the same cycle as a load reaches the live stage in that load.
- R8: While `chan_en` is low, a period or duty write updates its holding stage and its live stage in the same cycle, and the live stages follow the holding stages on every disabled cycle.
- R9: `rd_data` shows, combinationally from `rd_addr`, the period holding stage for address 0, the duty holding stage for address 1, the counter for address 2, and zero for address 3; writes use the same addresses on `wr_addr`.
- R10: A write of any data to address 2 sets the counter to 0 and the counting direction to upward on the next edge, wins over a `tick` in the same cycle, and loads both live stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 period, 1 duty, 2 counter |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes, 3 reads zero |
| rd_data | output | 8 | Read data |
| chan_en | input | 1 | Channel run enable |
| center_mode | input | 1 | 0 edge-aligned counting, 1 centred counting |
| tick | input | 1 | Clock-enable pulse from the prescaler |
| pwm_out | output | 1 | PWM output |

## Verification
The bench aims at period writes landing mid-cycle, where a design that loaded the live stage at once would emit a truncated or stretched cycle, and at writes coinciding with the closing tick, where a design that dropped the write-through would lag a whole cycle. Counter writes made together with a tick catch a design that lets the tick win and leaves the counter at 1. Period values of 0 and 1 in both counting styles, duty of 0 and duty above the period catch off-by-one wrap and turning-point errors that would show up as an extra or missing tick or a stuck output. Long random runs with gaps between ticks and enable toggling catch a counter that moves without a tick or a disabled channel that fails to track writes.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    localparam int unsigned PWM_W = 8;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_DUTY   = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    typedef enum logic {
        ALIGN_EDGE   = 1'b0,
        ALIGN_CENTER = 1'b1
    } align_e;

    typedef struct packed {
        logic period;
        logic duty;
        logic count;
    } wr_hits_t;

    localparam int unsigned N_SHADOW = 2;
    localparam int unsigned IDX_PER  = 0;
    localparam int unsigned IDX_DUTY = 1;

    function automatic wr_hits_t decode_write(input logic en, input logic [1:0] addr);
        wr_hits_t h;
        h.period = en && (reg_sel_e'(addr) == SEL_PERIOD);
        h.duty   = en && (reg_sel_e'(addr) == SEL_DUTY);
        h.count  = en && (reg_sel_e'(addr) == SEL_COUNT);
        return h;
    endfunction

endpackage

// File: rtl/pwm_dbuf_shadow.sv
module pwm_dbuf_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] held_q,
    output logic [W-1:0] live_q
);

    logic [W-1:0] load_val;

    // a write in the same cycle as a load goes straight through
    always_comb begin
        load_val = wr_hit ? wr_data : held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            live_q <= '0;
        end else begin
            if (wr_hit) begin
                held_q <= wr_data;
            end
            if (load) begin
                live_q <= load_val;
            end
        end
    end

endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter
    import pwm_dbuf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         chan_en,
    input  logic         tick,
    input  align_e       align,
    input  logic         clear,
    input  logic [W-1:0] per_live,
    output logic [W-1:0] cnt_q,
    output logic         cycle_end
);

    localparam int WX = W + 1;

    cnt_dir_e     dir_q;
    cnt_dir_e     dir_d;
    logic [W-1:0] cnt_d;
    logic [WX-1:0] cnt_inc;
    logic         per_zero;

    always_comb begin
        cnt_inc  = {1'b0, cnt_q} + WX'(1);
        per_zero = (per_live == '0);
    end

    always_comb begin
        cnt_d     = cnt_q;
        dir_d     = dir_q;
        cycle_end = 1'b0;
        if (!chan_en || clear) begin
            cnt_d = '0;
            dir_d = DIR_UP;
        end else if (tick) begin
            if (align == ALIGN_EDGE) begin
                dir_d = DIR_UP;
                if (cnt_inc >= {1'b0, per_live}) begin
                    cnt_d     = '0;
                    cycle_end = 1'b1;
                end else begin
                    cnt_d = cnt_inc[W-1:0];
                end
            end else if (per_zero) begin
                cnt_d     = '0;
                dir_d     = DIR_UP;
                cycle_end = 1'b1;
            end else if (dir_q == DIR_UP) begin
                cnt_d = cnt_inc[W-1:0];
                if (cnt_inc >= {1'b0, per_live}) begin
                    dir_d = DIR_DOWN;
                end
            end else begin
                if (cnt_q <= W'(1)) begin
                    cnt_d     = '0;
                    dir_d     = DIR_UP;
                    cycle_end = 1'b1;
                end else begin
                    cnt_d = cnt_q - W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

endmodule

// File: rtl/pwm_dbuf_regport.sv
module pwm_dbuf_regport
    import pwm_dbuf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [1:0]   rd_addr,
    input  logic [W-1:0] per_held,
    input  logic [W-1:0] duty_held,
    input  logic [W-1:0] cnt_val,
    output wr_hits_t     hits,
    output logic [W-1:0] rd_data
);

    always_comb begin
        hits = decode_write(wr_en, wr_addr);
    end

    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            SEL_PERIOD: rd_data = per_held;
            SEL_DUTY:   rd_data = duty_held;
            SEL_COUNT:  rd_data = cnt_val;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
    import pwm_dbuf_pkg::*;
#(
    parameter int W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   rd_addr,
    output logic [W-1:0] rd_data,
    input  logic         chan_en,
    input  logic         center_mode,
    input  logic         tick,
    output logic         pwm_out
);

    wr_hits_t     hits;
    logic [W-1:0] held_q [N_SHADOW];
    logic [W-1:0] live_q [N_SHADOW];
    logic         hit_vec [N_SHADOW];
    logic [W-1:0] cnt_val;
    logic         cycle_end;
    logic         shadow_load;
    logic [W-1:0] per_act;
    logic [W-1:0] duty_act;
    logic [W-1:0] per_buf;
    logic [W-1:0] duty_buf;
    align_e       align;

    always_comb begin
        align             = center_mode ? ALIGN_CENTER : ALIGN_EDGE;
        hit_vec[IDX_PER]  = hits.period;
        hit_vec[IDX_DUTY] = hits.duty;
        // safe points: disabled, cycle closed, counter written
        shadow_load       = !chan_en || cycle_end || hits.count;
        per_act           = live_q[IDX_PER];
        duty_act          = live_q[IDX_DUTY];
        per_buf           = held_q[IDX_PER];
        duty_buf          = held_q[IDX_DUTY];
    end

    pwm_dbuf_regport #(.W(W)) u_regs (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .per_held  (per_buf),
        .duty_held (duty_buf),
        .cnt_val   (cnt_val),
        .hits      (hits),
        .rd_data   (rd_data)
    );

    for (genvar i = 0; i < N_SHADOW; i++) begin : g_shadow
        pwm_dbuf_shadow #(.W(W)) u_shadow (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (hit_vec[i]),
            .wr_data (wr_data),
            .load    (shadow_load),
            .held_q  (held_q[i]),
            .live_q  (live_q[i])
        );
    end

    pwm_dbuf_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .chan_en   (chan_en),
        .tick      (tick),
        .align     (align),
        .clear     (hits.count),
        .per_live  (per_act),
        .cnt_q     (cnt_val),
        .cycle_end (cycle_end)
    );

    always_comb begin
        pwm_out = chan_en && (cnt_val < duty_act);
    end

endmodule

// File: rtl/pwm_dbuf_chan_chk.sv
module pwm_dbuf_chan_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [1:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic         chan_en,
    input logic         center_mode,
    input logic         tick,
    input logic         pwm_out,
    input logic [W-1:0] cnt_val,
    input logic [W-1:0] per_act,
    input logic         cycle_end
);

    logic cnt_wr;
    logic per_wr;
    always_comb begin
        cnt_wr = wr_en && (wr_addr == 2'd2);
        per_wr = wr_en && (wr_addr == 2'd0);
    end

    // R2
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
        !chan_en |-> !pwm_out);

    // R2
    disabled_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> cnt_val == '0);

    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !tick && !cnt_wr) |=> $stable(cnt_val));

    // R4
    edge_step_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && tick && !center_mode && !cnt_wr && per_act > W'(1)
         && cnt_val < per_act - W'(1)) |=> cnt_val == $past(cnt_val) + W'(1));

    // R5
    center_turn_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && tick && center_mode && !cnt_wr && per_act != '0
         && cnt_val == per_act) |=> cnt_val == $past(cnt_val) - W'(1));

    // R7
    live_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !cycle_end && !cnt_wr) |=> $stable(per_act));

    // R8
    disabled_through_chk: assert property (@(posedge clk) disable iff (rst)
        (!chan_en && per_wr) |=> per_act == $past(wr_data));

    // R10
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt_val == '0);

endmodule

bind pwm_dbuf_chan pwm_dbuf_chan_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .chan_en     (chan_en),
    .center_mode (center_mode),
    .tick        (tick),
    .pwm_out     (pwm_out),
    .cnt_val     (cnt_val),
    .per_act     (per_act),
    .cycle_end   (cycle_end)
);

// File: tb/pwm_dbuf_chan_tb.sv
module pwm_dbuf_chan_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       chan_en = 1'b0;
    logic       center_mode = 1'b0;
    logic       tick = 1'b0;
    logic       pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt = 0, m_pbuf = 0, m_pact = 0, m_dbuf = 0, m_dact = 0;
    bit m_up = 1'b1;

    always #2 clk = ~clk;

    pwm_dbuf_chan u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .chan_en(chan_en),
        .center_mode(center_mode), .tick(tick), .pwm_out(pwm_out)
    );

    always @(posedge clk) begin
        int np, nd;
        bit cw, closed;
        started = 1'b1;
        cycles++;
        if (rst) begin
            m_cnt = 0; m_pbuf = 0; m_pact = 0; m_dbuf = 0; m_dact = 0; m_up = 1'b1;
        end else begin
            np = m_pbuf; nd = m_dbuf; closed = 1'b0;
            if (wr_en && wr_addr == 2'd0) np = wr_data;
            if (wr_en && wr_addr == 2'd1) nd = wr_data;
            cw = wr_en && wr_addr == 2'd2;
            if (!chan_en || cw) begin
                m_cnt = 0; m_up = 1'b1;
            end else if (tick) begin
                if (!center_mode) begin
                    m_up = 1'b1;
                    if (m_cnt + 1 >= m_pact) begin m_cnt = 0; closed = 1'b1; end
                    else m_cnt++;
                end else if (m_pact == 0) begin
                    m_cnt = 0; m_up = 1'b1; closed = 1'b1;
                end else if (m_up) begin
                    m_cnt++;
                    if (m_cnt >= m_pact) m_up = 1'b0;
                end else if (m_cnt <= 1) begin
                    m_cnt = 0; m_up = 1'b1; closed = 1'b1;
                end else m_cnt--;
            end
            if (!chan_en || cw || closed) begin m_pact = np; m_dact = nd; end
            m_pbuf = np; m_dbuf = nd;
        end
    end

    function automatic int exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_pbuf;
            2'd1: return m_dbuf;
            2'd2: return m_cnt;
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        int e_out, e_rd;
        if (started && !done) begin
            e_out = (chan_en && m_cnt < m_dact) ? 1 : 0;
            e_rd  = exp_rd(rd_addr);
            n_cmp += 2;
            if (int'(pwm_out) != e_out) begin
                n_bad++;
                $display("FAIL %s/R6 pwm_out act %0d exp %0d at cycle %0d", cur_req, pwm_out, e_out, cycles);
            end
            if (int'(rd_data) != e_rd) begin
                n_bad++;
                $display("FAIL %s/R9 rd_data[addr %0d] act %0d exp %0d at cycle %0d",
                         cur_req, rd_addr, rd_data, e_rd, cycles);
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b0;
            rd_addr = rd_addr + 2'd1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        rd_addr = a;
    endtask

    task automatic run_ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b0;
            tick = (gap <= 1) ? 1'b1 : ((i % gap) == 0);
            rd_addr = 2'(i % 4);
        end
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    task automatic direct(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s direct act %0d exp %0d", req, act, exp);
        end
    endtask

    initial begin
        cur_req = "R1";
        cyc(3);
        @(posedge clk); #1; rst = 1'b0;
        #1;
        rd_addr = 2'd0; #0.1; direct("R1", rd_data, 0);
        direct("R1", pwm_out, 0);

        cur_req = "R8";
        wr(2'd0, 8'd5); wr(2'd1, 8'd2); cyc(1);
        cur_req = "R2";
        tick = 1'b1; cyc(6); tick = 1'b0;
        #0.5; rd_addr = 2'd2; #0.1; direct("R2", rd_data, 0);
        rd_addr = 2'd3; #0.1; direct("R9", rd_data, 0);

        cur_req = "R4";
        chan_en = 1'b1;
        run_ticks(30, 1);
        cur_req = "R3";
        run_ticks(30, 3);

        cur_req = "R7";
        run_ticks(2, 1);
        wr(2'd0, 8'd8); wr(2'd1, 8'd6);
        #0.5; rd_addr = 2'd0; #0.1; direct("R9", rd_data, 8);
        run_ticks(40, 1);

        cur_req = "R10";
        run_ticks(3, 1);
        @(posedge clk); #1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'hA5; tick = 1'b1;
        @(posedge clk); #1; wr_en = 1'b0; tick = 1'b0; rd_addr = 2'd2;
        #0.5; direct("R10", rd_data, 0);
        run_ticks(20, 1);

        cur_req = "R5";
        chan_en = 1'b0; cyc(1); center_mode = 1'b1;
        wr(2'd0, 8'd4); wr(2'd1, 8'd1); cyc(1);
        chan_en = 1'b1;
        run_ticks(30, 1);
        wr(2'd1, 8'd0); run_ticks(20, 1);
        wr(2'd1, 8'd9); run_ticks(20, 2);
        wr(2'd0, 8'd1); wr(2'd1, 8'd1); run_ticks(12, 1);
        wr(2'd0, 8'd0); run_ticks(12, 1);
        wr(2'd0, 8'd6); wr(2'd1, 8'd3); run_ticks(40, 1);

        cur_req = "R4";
        chan_en = 1'b0; cyc(1); center_mode = 1'b0; chan_en = 1'b1;
        wr(2'd0, 8'd1); run_ticks(10, 1);
        wr(2'd0, 8'd0); run_ticks(10, 1);
        wr(2'd0, 8'd255); wr(2'd1, 8'd128); run_ticks(600, 1);

        cur_req = "R7";
        for (int i = 0; i < 2500; i++) begin
            @(posedge clk); #1;
            tick = ($urandom_range(0, 2) != 0);
            wr_en = ($urandom_range(0, 9) == 0);
            wr_addr = 2'($urandom_range(0, 3));
            wr_data = 8'($urandom_range(0, 12));
            rd_addr = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 59) == 0) chan_en = ~chan_en;
            if (!chan_en && $urandom_range(0, 1) == 0) center_mode = ~center_mode;
        end
        @(posedge clk); #1; wr_en = 1'b0; tick = 1'b0;
        cyc(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog expired during %s", cur_req);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule